// File: doc/BRIEF.md
# Pixel Word Unpacker

The block sits between a pixel word FIFO and the data pins of a parallel RGB display. On every cycle in which the display timing generator asks for a pixel, the block gives one pixel to the display bus. It takes 32-bit words from the FIFO through a valid/ready handshake, but only when it needs a new word.

Three static configuration inputs set how each word is unpacked:

- **Word length.** A word is either two RGB565 pixels or one 24-bit colour.
- **Byte mask.** The mask says which bytes of the word carry data.
- **Bus width.** The bus width sets how the colour is placed on the pins. A narrow colour is widened by copying its top bits into the new low bits. A wide colour is narrowed by dropping its low bits.

If a pixel is requested and no data is available, the block sends a black pixel and sets a sticky underflow flag.

Top module: `pixel_word_unpacker`

## Requirements
- R1: After reset, `pix_de`, `pix_data`, `underflow` and `wd_ready` are all 0.
- R2: `pix_de` is `de_req` delayed by one clock. `pix_data` is 0 in every cycle where `pix_de` is 0.
- R3: Word length code 3 selects full-colour mode. Each request pops one word. Red is taken from bits 23:16, green from 15:8 and blue from 7:0. Bits 31:24 are ignored.
- R4: Word length code 0 selects halfword mode. The low halfword (bits 15:0) is sent first. The high halfword (bits 31:16) is sent on the next request, and no word is popped on that request. If mask bits 3:2 are both 0, the high halfword is skipped, so each word gives one pixel.
- R5: A byte whose mask bit is 0 (mask bit i covers bits 8i+7:8i) reads as zero before the pixel is formed.
- R6: In halfword mode, a halfword holds red in bits 15:11, green in bits 10:5 and blue in bits 4:0.
- R7: The bus width code sets the pin layout:
  - Code 3: `pix_data` = {R8, G8, B8}.
  - Code 2: bits 17:0 = {R6, G6, B6}, and the upper bits are 0.
  - Code 0: bits 15:0 = {R5, G6, B5}, and the upper bits are 0.
  - Code 1: `pix_data` is all zero.
- R8: A 5-bit or 6-bit channel is widened by copying its most significant bits into the new low bits. A channel is narrowed by keeping its most significant bits.
- R9: A request with no pending halfword and an empty FIFO gives a zero pixel. It also sets `underflow`, which stays set until reset.
- R10: Word length codes 1 and 2 are unsupported. With either code, no word is popped, requested pixels are zero, and `underflow` is not set.
- R11: `wd_ready` is high only while `de_req` is high, a supported word length is selected, and no high halfword is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| cfg_word_len | input | 2 | Word length code: 0 = two RGB565 pixels per word, 3 = one 24-bit pixel per word, 1 and 2 unsupported |
| cfg_byte_mask | input | 4 | Valid-byte mask; bit i covers word bits 8i+7:8i |
| cfg_bus_width | input | 2 | Bus width code: 0 = 16-bit, 1 = 8-bit (drives zero), 2 = 18-bit, 3 = 24-bit |
| de_req | input | 1 | Pixel request from the timing generator |
| wd_valid | input | 1 | FIFO word available |
| wd_ready | output | 1 | Word popped this cycle when `wd_valid` is also high |
| wd_data | input | 32 | FIFO word |
| pix_de | output | 1 | Data enable aligned with `pix_data` |
| pix_data | output | 24 | Display data pins |
| underflow | output | 1 | Sticky flag: a pixel was requested with no data available |

## Verification
- **Handshake.** `wd_ready` is combinational, so a pop takes effect at the same clock edge that samples `de_req`.
- **Pixel and enable.** The pixel and its enable appear one edge later.
- **Underflow.** The underflow flag also rises one edge after the request that found the FIFO empty.

The bench changes inputs just after a rising edge and samples on the falling edge. A scoreboard pairs each high `pix_de` with the next expected pixel, in order. FIFO pointer checks are made one full cycle after each request, when the pop they test has already happened.

// File: rtl/pwu_pkg.sv
package pwu_pkg;
  localparam int WORD_W     = 32;
  localparam int BYTE_W     = 8;
  localparam int MASK_W     = WORD_W / BYTE_W;
  localparam int HALF_W     = WORD_W / 2;
  localparam int CH_W       = 8;
  localparam int BUS_W      = 3 * CH_W;
  localparam int R5_W       = 5;
  localparam int G6_W       = 6;
  localparam int B5_W       = 5;
  localparam int C6_W       = 6;
  localparam int RST_STAGES = 2;

  typedef enum logic [1:0] {
    WL_HALF  = 2'd0,
    WL_RSV1  = 2'd1,
    WL_RSV2  = 2'd2,
    WL_FULL  = 2'd3
  } wlen_e;

  typedef enum logic [1:0] {
    BW_16 = 2'd0,
    BW_8  = 2'd1,
    BW_18 = 2'd2,
    BW_24 = 2'd3
  } busw_e;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/pwu_fetch.sv
module pwu_fetch
  import pwu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de_req,
  input  logic              half_mode,
  input  logic              full_mode,
  input  logic              hi_used,
  input  logic              wd_valid,
  input  logic [WORD_W-1:0] wd_data,
  output logic              wd_ready,
  output logic              src_vld,
  output logic              src_hi,
  output logic [WORD_W-1:0] src_word,
  output logic              underflow
);
  logic              supp;
  logic              take;
  logic              pend_q, pend_d;
  logic [WORD_W-1:0] hold_q;
  logic              hold_en;
  logic              udf_q, udf_d;

  // next-state logic
  always_comb begin
    supp     = half_mode | full_mode;
    wd_ready = de_req & supp & ~pend_q;
    take     = wd_ready & wd_valid;
    src_vld  = de_req & supp & (pend_q | wd_valid);
    src_hi   = pend_q;
    src_word = pend_q ? hold_q : wd_data;
    hold_en  = take & half_mode & hi_used;
    pend_d   = pend_q;
    if (de_req && pend_q && supp) begin
      pend_d = 1'b0;
    end else if (hold_en) begin
      pend_d = 1'b1;
    end
    udf_d = udf_q | (wd_ready & ~wd_valid);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      udf_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      udf_q  <= udf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= wd_data;
    end
  end

  assign underflow = udf_q;
endmodule

// File: rtl/pwu_expand.sv
module pwu_expand
  import pwu_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              hi_i,
  input  logic              half_mode,
  input  logic [MASK_W-1:0] mask_i,
  output rgb_t              rgb_o
);
  localparam int R_LO = G6_W + B5_W;
  localparam int G_LO = B5_W;

  logic [WORD_W-1:0] masked;
  logic [HALF_W-1:0] hw;
  logic [R5_W-1:0]   r5;
  logic [G6_W-1:0]   g6;
  logic [B5_W-1:0]   b5;

  // zero every byte whose mask bit is clear
  for (genvar gi = 0; gi < MASK_W; gi++) begin : g_byte
    assign masked[gi*BYTE_W +: BYTE_W] = mask_i[gi] ? word_i[gi*BYTE_W +: BYTE_W]
                                                     : {BYTE_W{1'b0}};
  end

  always_comb begin
    hw = hi_i ? masked[WORD_W-1:HALF_W] : masked[HALF_W-1:0];
    r5 = hw[R_LO +: R5_W];
    g6 = hw[G_LO +: G6_W];
    b5 = hw[0 +: B5_W];
    if (half_mode) begin
      // widen by copying the top bits into the new low bits
      rgb_o.r = {r5, r5[R5_W-1 -: CH_W-R5_W]};
      rgb_o.g = {g6, g6[G6_W-1 -: CH_W-G6_W]};
      rgb_o.b = {b5, b5[B5_W-1 -: CH_W-B5_W]};
    end else begin
      rgb_o.r = masked[2*CH_W +: CH_W];
      rgb_o.g = masked[CH_W +: CH_W];
      rgb_o.b = masked[0 +: CH_W];
    end
  end
endmodule

// File: rtl/pwu_busmap.sv
module pwu_busmap
  import pwu_pkg::*;
(
  input  rgb_t             rgb_i,
  input  logic [1:0]       bus_w,
  output logic [BUS_W-1:0] bus_o
);
  localparam int W18  = 3 * C6_W;
  localparam int W16  = R5_W + G6_W + B5_W;
  localparam int PAD18 = BUS_W - W18;
  localparam int PAD16 = BUS_W - W16;

  logic [W18-1:0] p18;
  logic [W16-1:0] p16;

  always_comb begin
    // narrow by keeping the most significant bits
    p18 = {rgb_i.r[CH_W-1 -: C6_W], rgb_i.g[CH_W-1 -: C6_W], rgb_i.b[CH_W-1 -: C6_W]};
    p16 = {rgb_i.r[CH_W-1 -: R5_W], rgb_i.g[CH_W-1 -: G6_W], rgb_i.b[CH_W-1 -: B5_W]};
    case (bus_w)
      BW_24:   bus_o = rgb_i;
      BW_18:   bus_o = {{PAD18{1'b0}}, p18};
      BW_16:   bus_o = {{PAD16{1'b0}}, p16};
      default: bus_o = '0;
    endcase
  end
endmodule

// File: rtl/pixel_word_unpacker.sv
module pixel_word_unpacker
  import pwu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_word_len,
  input  logic [MASK_W-1:0] cfg_byte_mask,
  input  logic [1:0]        cfg_bus_width,
  input  logic              de_req,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [WORD_W-1:0] wd_data,
  output logic              pix_de,
  output logic [BUS_W-1:0]  pix_data,
  output logic              underflow
);
  logic [RST_STAGES-1:0] rs_q;
  logic                  rst_sync_n;
  logic                  half_mode, full_mode, hi_used;
  logic                  src_vld, src_hi;
  logic [WORD_W-1:0]     src_word;
  rgb_t                  rgb;
  logic [BUS_W-1:0]      bus_val;
  logic [BUS_W-1:0]      pix_d, pix_q;
  logic                  de_d, de_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rs_q[RST_STAGES-1];

  assign half_mode = (cfg_word_len == WL_HALF);
  assign full_mode = (cfg_word_len == WL_FULL);
  assign hi_used   = |cfg_byte_mask[MASK_W-1:MASK_W/2];

  pwu_fetch u_fetch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .de_req    (de_req),
    .half_mode (half_mode),
    .full_mode (full_mode),
    .hi_used   (hi_used),
    .wd_valid  (wd_valid),
    .wd_data   (wd_data),
    .wd_ready  (wd_ready),
    .src_vld   (src_vld),
    .src_hi    (src_hi),
    .src_word  (src_word),
    .underflow (underflow)
  );

  pwu_expand u_expand (
    .word_i    (src_word),
    .hi_i      (src_hi),
    .half_mode (half_mode),
    .mask_i    (cfg_byte_mask),
    .rgb_o     (rgb)
  );

  pwu_busmap u_busmap (
    .rgb_i (rgb),
    .bus_w (cfg_bus_width),
    .bus_o (bus_val)
  );

  always_comb begin
    de_d  = de_req;
    pix_d = src_vld ? bus_val : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      de_q  <= 1'b0;
      pix_q <= '0;
    end else begin
      de_q  <= de_d;
      pix_q <= pix_d;
    end
  end

  assign pix_de   = de_q;
  assign pix_data = pix_q;
endmodule

// File: rtl/pwu_chk.sv
module pwu_chk
  import pwu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_word_len,
  input logic [1:0]       cfg_bus_width,
  input logic             de_req,
  input logic             wd_valid,
  input logic             wd_ready,
  input logic             pix_de,
  input logic [BUS_W-1:0] pix_data,
  input logic             underflow
);
  // R2
  de_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_req |=> pix_de);
  // R2
  de_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !de_req |=> !pix_de);
  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_de |-> (pix_data == '0));
  // R9
  udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  // R9
  udf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_ready && !wd_valid) |=> underflow);
  // R11
  ready_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |-> de_req);
  // R10
  rsvd_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word_len == 2'd1 || cfg_word_len == 2'd2) |-> !wd_ready);
  // R7
  bus16_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de_req && cfg_bus_width == 2'd0) |=> (pix_data[BUS_W-1:16] == '0));
  // R7
  bus8_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de_req && cfg_bus_width == 2'd1) |=> (pix_data == '0));
endmodule

bind pixel_word_unpacker pwu_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .cfg_word_len  (cfg_word_len),
  .cfg_bus_width (cfg_bus_width),
  .de_req        (de_req),
  .wd_valid      (wd_valid),
  .wd_ready      (wd_ready),
  .pix_de        (pix_de),
  .pix_data      (pix_data),
  .underflow     (underflow)
);

// File: tb/pixel_word_unpacker_tb.sv
`timescale 1ns/1ps
module pixel_word_unpacker_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_word_len;
  logic [3:0]  cfg_byte_mask;
  logic [1:0]  cfg_bus_width;
  logic        de_req;
  logic        wd_valid;
  logic        wd_ready;
  logic [31:0] wd_data;
  logic        pix_de;
  logic [23:0] pix_data;
  logic        underflow;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit mon_en = 0;
  logic de_hist = 1'b0;

  logic [31:0] mem [64];
  int wr_ptr = 0;
  int rd_ptr = 0;
  logic [23:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  pixel_word_unpacker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word_len(cfg_word_len),
    .cfg_byte_mask(cfg_byte_mask), .cfg_bus_width(cfg_bus_width),
    .de_req(de_req), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .wd_data(wd_data), .pix_de(pix_de), .pix_data(pix_data),
    .underflow(underflow)
  );

  // FIFO model
  assign wd_valid = (rd_ptr != wr_ptr);
  assign wd_data  = mem[rd_ptr % 64];
  always @(posedge clk) if (wd_valid && wd_ready) rd_ptr <= rd_ptr + 1;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // expected pixel from the requirements
  function automatic logic [23:0] model(logic [31:0] w, bit hi, logic [1:0] wl,
                                        logic [3:0] m, logic [1:0] bw);
    logic [31:0] mw;
    logic [15:0] h;
    logic [7:0]  r, g, b;
    for (int i = 0; i < 4; i++) mw[i*8 +: 8] = m[i] ? w[i*8 +: 8] : 8'h00; // R5
    if (wl == 2'd3) begin
      r = mw[23:16]; g = mw[15:8]; b = mw[7:0];                           // R3
    end else begin
      h = hi ? mw[31:16] : mw[15:0];
      r = {h[15:11], h[15:13]}; g = {h[10:5], h[10:9]}; b = {h[4:0], h[4:2]}; // R6 R8
    end
    case (bw)                                                             // R7
      2'd3:    model = {r, g, b};
      2'd2:    model = {6'd0, r[7:2], g[7:2], b[7:2]};
      2'd0:    model = {8'd0, r[7:3], g[7:2], b[7:3]};
      default: model = 24'd0;
    endcase
  endfunction

  task automatic push_word(logic [31:0] w);
    mem[wr_ptr % 64] = w;
    wr_ptr++;
  endtask

  task automatic push_exp(logic [23:0] v, string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // driver: word into FIFO, expected pixels into the scoreboard
  task automatic send(logic [31:0] w, string tag);
    push_word(w);
    push_exp(model(w, 1'b0, cfg_word_len, cfg_byte_mask, cfg_bus_width), tag);
    if (cfg_word_len == 2'd0 && cfg_byte_mask[3:2] != 2'b00)
      push_exp(model(w, 1'b1, cfg_word_len, cfg_byte_mask, cfg_bus_width), tag);
  endtask

  task automatic drive_de(bit v);
    @(posedge clk); #1; de_req = v;
  endtask

  task automatic run_de(int n);
    repeat (n) drive_de(1'b1);
    repeat (4) drive_de(1'b0);
  endtask

  task automatic set_cfg(logic [1:0] wl, logic [3:0] m, logic [1:0] bw);
    @(posedge clk); #1;
    cfg_word_len = wl; cfg_byte_mask = m; cfg_bus_width = bw;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_en) begin
      chk(pix_de == de_hist, "R2 enable delay", {31'd0, pix_de}, {31'd0, de_hist});
      if (pix_de) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected pixel", {8'd0, pix_data}, 32'd0);
        end else begin
          logic [23:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(pix_data == e, t, {8'd0, pix_data}, {8'd0, e});
        end
      end else begin
        chk(pix_data == 24'd0, "R2 idle zero", {8'd0, pix_data}, 32'd0);
      end
      de_hist = de_req;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0;
    rst_n = 1'b0; de_req = 1'b0;
    cfg_word_len = 2'd3; cfg_byte_mask = 4'h7; cfg_bus_width = 2'd3;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(pix_de == 1'b0,    "R1 pix_de",    {31'd0, pix_de}, 32'd0);
    chk(pix_data == 24'd0, "R1 pix_data",  {8'd0, pix_data}, 32'd0);
    chk(underflow == 1'b0, "R1 underflow", {31'd0, underflow}, 32'd0);
    chk(wd_ready == 1'b0,  "R1 wd_ready",  {31'd0, wd_ready}, 32'd0);
    mon_en = 1'b1;

    // R3 full colour on 24-bit bus, top byte ignored
    send(32'hAB123456, "R3 full colour"); send(32'hFF00FF80, "R3 full colour");
    send(32'h5AC33C0F, "R3 full colour");
    run_de(3);
    // R7 18-bit and 16-bit layouts of full colour
    set_cfg(2'd3, 4'h7, 2'd2);
    send(32'h00FC8403, "R7 bus18"); send(32'h77A1B2C3, "R7 bus18");
    run_de(2);
    set_cfg(2'd3, 4'h7, 2'd0);
    send(32'h00F8FC1F, "R7 bus16"); send(32'h11396E8A, "R7 bus16");
    run_de(2);

    // R4 R6 R8 halfword mode, two pixels per word
    set_cfg(2'd0, 4'hF, 2'd3);
    send(32'h1234F81F, "R6 R8 half to 24"); send(32'h07E08410, "R6 R8 half to 24");
    run_de(4);
    set_cfg(2'd0, 4'hF, 2'd2);
    send(32'hA5A5F00F, "R8 half to 18"); send(32'h0821FFFF, "R8 half to 18");
    run_de(4);
    set_cfg(2'd0, 4'hF, 2'd0);
    send(32'hBEEF1357, "R7 half to 16");
    run_de(2);

    // R4 pop happens only after both halves are used
    set_cfg(2'd0, 4'hF, 2'd3);
    p0 = rd_ptr;
    send(32'h9ABC1DEF, "R4 order"); send(32'h2468ACE1, "R4 order");
    drive_de(1'b1);
    drive_de(1'b1); chk(rd_ptr == p0 + 1, "R4 first pop",  rd_ptr, p0 + 1);
    drive_de(1'b1); chk(rd_ptr == p0 + 1, "R4 held half",  rd_ptr, p0 + 1);
    drive_de(1'b1); chk(rd_ptr == p0 + 2, "R4 second pop", rd_ptr, p0 + 2);
    drive_de(1'b0); chk(rd_ptr == p0 + 2, "R4 no extra pop", rd_ptr, p0 + 2);
    repeat (3) drive_de(1'b0);

    // R4 upper halfword unused: one pixel per word
    set_cfg(2'd0, 4'h3, 2'd3);
    send(32'hFFFF1234, "R4 single half"); send(32'hFFFFABCD, "R4 single half");
    run_de(2);
    chk(rd_ptr == wr_ptr, "R4 words consumed", rd_ptr, wr_ptr);

    // R5 masked bytes read as zero
    set_cfg(2'd3, 4'h5, 2'd3);
    send(32'h11223344, "R5 mask full");
    run_de(1);
    set_cfg(2'd0, 4'hD, 2'd3);
    send(32'h8899AABB, "R5 mask half");
    run_de(2);

    // R11 no pop while de_req is low
    set_cfg(2'd3, 4'h7, 2'd3);
    p0 = rd_ptr;
    send(32'h00123456, "R11 after idle"); send(32'h00654321, "R11 after idle");
    repeat (4) begin
      drive_de(1'b0);
      chk(wd_ready == 1'b0, "R11 ready low", {31'd0, wd_ready}, 32'd0);
      chk(rd_ptr == p0, "R11 no pop", rd_ptr, p0);
    end
    run_de(2);

    // R7 8-bit bus code drives zero
    set_cfg(2'd3, 4'h7, 2'd1);
    send(32'h00FFFFFF, "R7 bus8 zero");
    run_de(1);

    // R10 unsupported word length
    set_cfg(2'd1, 4'h7, 2'd3);
    p0 = rd_ptr;
    push_word(32'h00C0FFEE);
    repeat (3) push_exp(24'd0, "R10 zero pixel");
    run_de(3);
    chk(rd_ptr == p0, "R10 no pop", rd_ptr, p0);
    chk(underflow == 1'b0, "R10 no underflow", {31'd0, underflow}, 32'd0);
    set_cfg(2'd3, 4'h7, 2'd3);
    push_exp(model(32'h00C0FFEE, 1'b0, 2'd3, 4'h7, 2'd3), "R10 word kept");
    run_de(1);

    // R9 underflow
    chk(rd_ptr == wr_ptr, "R9 fifo empty", rd_ptr, wr_ptr);
    repeat (2) push_exp(24'd0, "R9 zero pixel");
    run_de(2);
    chk(underflow == 1'b1, "R9 flag set", {31'd0, underflow}, 32'd1);
    send(32'h00010203, "R9 after underflow");
    run_de(1);
    chk(underflow == 1'b1, "R9 flag sticky", {31'd0, underflow}, 32'd1);

    repeat (3) drive_de(1'b0);
    chk(exp_q.size() == 0, "R2 all pixels seen", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule